// File: doc/BRIEF.md
# Multiword DMA Transfer Engine

This block moves a burst of 16-bit words between a parallel storage device port and a memory-side word stream using the request/acknowledge handshake of multiword DMA. Software programs two timing words, an interrupt enable and then a configuration word holding the run bit, the direction, a byte-swap option, a ride-through option and the transfer length. The length is given as the number of words minus one. Once the device raises its request line the engine asserts its acknowledge, waits a setup time, and issues one read or write strobe per word with programmable asserted and negated widths.

Each completed strobe decrements the length field. After the last word the engine holds acknowledge for a hold time, waits an end pause, clears its run bit and sets a sticky done flag that drives the interrupt when enabled. A completed transfer leaves the length field at all ones, so any other value read back after the run bit drops shows how many words were left when the burst was cut short. A memory stream that stalls simply delays the next strobe.

Top module: `mwdma_engine`

## Requirements
- R1: After reset the acknowledge output sits at its inactive level (high, since the polarity bit resets to 0), both strobes are high, the interrupt is low, the configuration word (address 0) reads 0x000FFFFF and the status word (address 3) reads 0.
- R2: The configuration word at address 0 carries the length in bits [19:0] as words minus one, direction in bit 20, swap in bit 21, ride-through disable in bit 22 and the run bit in bit 31; a transfer moves exactly length+1 words, one strobe each.
- R3: On completion the run bit reads 0, the length reads 0xFFFFF and status bit 0 (done) reads 1.
- R4: Writing 1 to status bit 0 clears done; the interrupt output equals done gated by bit 0 of the enable word at address 4.
- R5: Direction 0 reads from the device with the read strobe and delivers words on the output stream; direction 1 takes words from the input stream and writes them with the write strobe, driving the data bus; the other strobe stays high.
- R6: With swap set, the high and low bytes of every moved word are exchanged in both directions.
- R7: Each timing field f lasts (f+1)*M clocks, where M is the 2-bit multiplier field at address 1 bits [17:16] with encoding 0 meaning 4 and 1..3 meaning 1..3; strobe widths use address 2 fields: read on [3:0], read off [7:4], write on [11:8], write off [15:12].
- R8: Acknowledge is active for the setup span (address 1 bits [3:0]) before the first strobe and for the hold span (bits [7:4]) after the last; the end pause uses bits [11:8].
- R9: A burst starts or resumes only after the request line has been high for more than the request field (address 1 bits [15:12]) raw clocks, not scaled by M.
- R10: With bit 22 clear, a request drop between words pauses the burst with acknowledge held, and the burst completes in full once the request returns.
- R11: With bit 22 set, a request drop between words ends the burst: done is set, the run bit clears and the length reads words-left minus one.
- R12: Writing a configuration word with the run bit 0 and length 0xFFFFF stops the engine at once: acknowledge goes inactive on the next clock, no strobe follows and done is not set.
- R13: While the output stream is not ready (read) or the input stream has no word (write), no new strobe starts, and the negated time between strobes is never shorter than its programmed span.
- R14: Address 1 bit 18 sets the acknowledge polarity: 1 makes it active high, 0 active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt: done and enabled |
| dev_dmarq | input | 1 | Device DMA request |
| dev_ack | output | 1 | DMA acknowledge, polarity programmable |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Data driven to the device |
| dev_din | input | 16 | Data returned by the device |
| dev_drive | output | 1 | Data bus output enable |
| in_valid | input | 1 | Input stream word valid |
| in_data | input | 16 | Input stream word |
| in_ready | output | 1 | Input stream word taken |
| out_valid | output | 1 | Output stream word valid |
| out_data | output | 16 | Output stream word |
| out_ready | input | 1 | Output stream ready |

## Verification
A wrong length counter shows at the strobe pins as one word too many or too few, and in the length field read back after done, within the same burst. A timer or multiplier fault shows as a strobe or acknowledge interval of the wrong width on the very first word, so strobe widths and setup and hold spans are measured clock by clock. A stuck pause or ride-through state shows as strobes continuing while the request is low, or a burst that never finishes, within a few dozen clocks of the request edge. Swap and direction faults corrupt the first moved word.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;
  localparam int TFW  = 4;
  localparam int DURW = 7;
  localparam int AW   = 3;

  localparam logic [AW-1:0] A_CFG  = 3'd0;
  localparam logic [AW-1:0] A_TIMA = 3'd1;
  localparam logic [AW-1:0] A_TIMB = 3'd2;
  localparam logic [AW-1:0] A_STAT = 3'd3;
  localparam logic [AW-1:0] A_IEN  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STRB, ST_NEG, ST_HOLD, ST_PAUSE
  } mw_state_e;

  // msb first: ack_hi[18], mult[17:16], rq_min[15:12], pause[11:8], hold[7:4], setup[3:0]
  typedef struct packed {
    logic           ack_hi;
    logic [1:0]     mult;
    logic [TFW-1:0] rq_min;
    logic [TFW-1:0] pause;
    logic [TFW-1:0] hold;
    logic [TFW-1:0] setup;
  } tim_a_t;

  // msb first: wr_off[15:12], wr_on[11:8], rd_off[7:4], rd_on[3:0]
  typedef struct packed {
    logic [TFW-1:0] wr_off;
    logic [TFW-1:0] wr_on;
    logic [TFW-1:0] rd_off;
    logic [TFW-1:0] rd_on;
  } tim_b_t;

  // Clocks spent in a phase: (field + 1) * multiplier, encoding 0 = 4x.
  function automatic logic [DURW-1:0] span(input logic [TFW-1:0] f, input logic [1:0] m);
    logic [DURW-1:0] k;
    k = (m == 2'd0) ? DURW'(4) : DURW'(m);
    return (DURW'(f) + DURW'(1)) * k;
  endfunction

  function automatic logic [15:0] bswap(input logic [15:0] w, input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction
endpackage

// File: rtl/mwdma_regs.sv
module mwdma_regs
  import mwdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          finish,
  output tim_a_t        tim_a,
  output tim_b_t        tim_b,
  output logic          ie,
  output logic          done
);
  localparam int TAW = $bits(tim_a_t);
  localparam int TBW = $bits(tim_b_t);

  logic unused_hi;
  assign unused_hi = &{1'b0, wdata[31:TAW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_a <= '0;
      tim_b <= '0;
      ie    <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          A_TIMA:  tim_a <= wdata[TAW-1:0];
          A_TIMB:  tim_b <= wdata[TBW-1:0];
          A_IEN:   ie    <= wdata[0];
          A_STAT:  if (wdata[0]) done <= 1'b0;
          default: ;
        endcase
      end
      if (finish) done <= 1'b1;
    end
  end
endmodule

// File: rtl/mwdma_rqfilt.sv
module mwdma_rqfilt
  import mwdma_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dmarq,
  input  logic [TFW-1:0] min_hi,
  output logic           rq_ok
);
  logic [TFW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run <= '0;
    else if (!dmarq)         run <= '0;
    else if (run != '1)      run <= run + 1'b1;
  end

  assign rq_ok = dmarq && (run >= min_hi);
endmodule

// File: rtl/mwdma_seq.sv
module mwdma_seq
  import mwdma_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  tim_a_t           tim_a,
  input  tim_b_t           tim_b,
  input  logic             rq_ok,
  input  logic             dmarq,
  input  logic             in_valid,
  input  logic [15:0]      in_data,
  input  logic             out_ready,
  input  logic [15:0]      dev_din,
  output logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic             swap,
  output logic             clr,
  output logic             in_ready,
  output logic             out_valid,
  output logic [15:0]      out_data,
  output logic [15:0]      dev_dout,
  output logic             finish,
  output logic             abort,
  output logic             word_done,
  output logic             ack_on,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int B_DIR  = CNT_W;
  localparam int B_SWAP = CNT_W + 1;
  localparam int B_CLR  = CNT_W + 2;
  localparam int B_EN   = 31;

  mw_state_e       st, nst;
  logic [DURW-1:0] tmr, dur;
  logic            tdone, data_ok, go, load;

  logic unused_cfg;
  assign unused_cfg = &{1'b0, cfg_wdata[B_EN-1:B_CLR+1]};

  assign abort   = cfg_wr && !cfg_wdata[B_EN] && (&cfg_wdata[CNT_W-1:0]);
  assign load    = cfg_wr && (st == ST_IDLE) && !abort;
  assign tdone   = (tmr == '0);
  assign data_ok = dir ? in_valid : !out_valid;
  assign go      = tdone && rq_ok && data_ok;

  always_comb begin
    nst = st;
    case (st)
      ST_IDLE:  if (en && rq_ok) nst = ST_SETUP;
      ST_SETUP: if (go) nst = ST_STRB;
      ST_STRB:  if (tdone) nst = (cnt == '0) ? ST_HOLD : ST_NEG;
      ST_NEG:   if (clr && !dmarq) nst = ST_HOLD;
                else if (go) nst = ST_STRB;
      ST_HOLD:  if (tdone) nst = ST_PAUSE;
      ST_PAUSE: if (tdone) nst = ST_IDLE;
      default:  nst = ST_IDLE;
    endcase
  end

  always_comb begin
    case (nst)
      ST_SETUP: dur = span(tim_a.setup, tim_a.mult);
      ST_STRB:  dur = span(dir ? tim_b.wr_on : tim_b.rd_on, tim_a.mult);
      ST_NEG:   dur = span(dir ? tim_b.wr_off : tim_b.rd_off, tim_a.mult);
      ST_HOLD:  dur = span(tim_a.hold, tim_a.mult);
      ST_PAUSE: dur = span(tim_a.pause, tim_a.mult);
      default:  dur = DURW'(1);
    endcase
  end

  assign word_done = (st == ST_STRB) && tdone;
  assign finish    = (st == ST_PAUSE) && tdone;
  assign in_ready  = dir && go && ((st == ST_SETUP) || (st == ST_NEG));
  assign ack_on    = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_NEG) || (st == ST_HOLD);
  assign rd_n      = !((st == ST_STRB) && !dir);
  assign wr_n      = !((st == ST_STRB) && dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      en        <= 1'b0;
      cnt       <= '1;
      dir       <= 1'b0;
      swap      <= 1'b0;
      clr       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      dev_dout  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (abort) begin
        st   <= ST_IDLE;
        tmr  <= '0;
        en   <= 1'b0;
        cnt  <= '1;
        dir  <= cfg_wdata[B_DIR];
        swap <= cfg_wdata[B_SWAP];
        clr  <= cfg_wdata[B_CLR];
      end else begin
        if (load) begin
          en   <= cfg_wdata[B_EN];
          cnt  <= cfg_wdata[CNT_W-1:0];
          dir  <= cfg_wdata[B_DIR];
          swap <= cfg_wdata[B_SWAP];
          clr  <= cfg_wdata[B_CLR];
        end
        st <= nst;
        if (nst != st)       tmr <= dur - 1'b1;
        else if (!tdone)     tmr <= tmr - 1'b1;
        if (word_done) begin
          cnt <= cnt - 1'b1;
          if (!dir) begin
            out_valid <= 1'b1;
            out_data  <= bswap(dev_din, swap);
          end
        end
        if (in_ready) dev_dout <= bswap(in_data, swap);
        if (finish) en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mwdma_engine.sv
module mwdma_engine
  import mwdma_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          dev_dmarq,
  output logic          dev_ack,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [15:0]   dev_dout,
  input  logic [15:0]   dev_din,
  output logic          dev_drive,
  input  logic          in_valid,
  input  logic [15:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [15:0]   out_data,
  input  logic          out_ready
);
  tim_a_t           tim_a;
  tim_b_t           tim_b;
  logic             ie, done, rq_ok;
  logic             en, dir, swap, clr;
  logic [CNT_W-1:0] cnt;
  // named internal events, observed by the bound checker
  logic             ev_finish, ev_abort, ev_word, ack_on;

  mwdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .finish(ev_finish), .tim_a(tim_a), .tim_b(tim_b), .ie(ie), .done(done)
  );

  mwdma_rqfilt u_rq (
    .clk(clk), .rst_n(rst_n), .dmarq(dev_dmarq), .min_hi(tim_a.rq_min), .rq_ok(rq_ok)
  );

  mwdma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(reg_wr && (reg_addr == A_CFG)), .cfg_wdata(reg_wdata),
    .tim_a(tim_a), .tim_b(tim_b), .rq_ok(rq_ok), .dmarq(dev_dmarq),
    .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready), .dev_din(dev_din),
    .en(en), .cnt(cnt), .dir(dir), .swap(swap), .clr(clr),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .dev_dout(dev_dout),
    .finish(ev_finish), .abort(ev_abort), .word_done(ev_word), .ack_on(ack_on),
    .rd_n(dev_rd_n), .wr_n(dev_wr_n)
  );

  assign dev_ack   = tim_a.ack_hi ? ack_on : !ack_on;
  assign dev_drive = ack_on && dir;
  assign irq       = done && ie;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: begin
        reg_rdata[CNT_W-1:0] = cnt;
        reg_rdata[CNT_W]     = dir;
        reg_rdata[CNT_W+1]   = swap;
        reg_rdata[CNT_W+2]   = clr;
        reg_rdata[31]        = en;
      end
      A_TIMA:  reg_rdata[$bits(tim_a_t)-1:0] = tim_a;
      A_TIMB:  reg_rdata[$bits(tim_b_t)-1:0] = tim_b;
      A_STAT:  reg_rdata[0] = done;
      A_IEN:   reg_rdata[0] = ie;
      default: ;
    endcase
  end
endmodule

// File: rtl/mwdma_chk.sv
module mwdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_on,
  input logic        rd_n,
  input logic        wr_n,
  input logic        finish,
  input logic        abort,
  input logic        en,
  input logic        done,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);
  // R5: never both strobes at once
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R8: a strobe only ever occurs inside an acknowledge window
  a_r8_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> ack_on);

  // R3: the end of a burst drops the run bit and raises done
  a_r3_finish_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!en && done));

  // R4: done only rises because a burst ended
  a_r4_done_from_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(finish));

  // R12: a stop write idles the engine on the next clock
  a_r12_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!ack_on && rd_n && wr_n && !en));

  // R13: a stalled output word is held unchanged
  a_r13_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind mwdma_engine mwdma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_on(ack_on), .rd_n(dev_rd_n), .wr_n(dev_wr_n),
  .finish(ev_finish), .abort(ev_abort), .en(en), .done(done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_mwdma_engine.sv
`timescale 1ns/1ps
module test_mwdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dev_ack, dev_rd_n, dev_wr_n, dev_drive;
  logic        dev_dmarq = 1'b0;
  logic [15:0] dev_dout, out_data, in_data;
  logic [15:0] dev_din = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;

  always #2 clk = ~clk;

  mwdma_engine i_mwdma_engine (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] rbase = 16'h1234, wbase = 16'h4321;
  logic        ack_hi_b = 1'b0;

  function automatic logic [15:0] rpat(input int i);
    return rbase ^ (16'(i) * 16'h0F1D) ^ 16'h8000;
  endfunction
  function automatic logic [15:0] wpat(input int i);
    return wbase + (16'(i) * 16'h2B07);
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] w, input logic s);
    logic [15:0] r;
    r = w;
    if (s) r = {w[7:0], w[15:8]};
    return r;
  endfunction
  function automatic int dcl(input int f, input int m);
    int k;
    k = (m == 0) ? 4 : m;
    return k + f * k;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // device / stream model, sampled away from the active edge
  int widx = 0;
  assign in_data = wpat(widx);
  always @(posedge clk) if (in_ready && in_valid) widx <= widx + 1;

  logic [15:0] olog [256];
  logic [15:0] wlog [256];
  int nstrb, nrd, nwr, nout, low_run, idle_run, wmin, wmax, gap_min, setup_seen, hold_seen;
  bit p_strb, p_act, first;

  task automatic clear_stats();
    nstrb = 0; nrd = 0; nwr = 0; nout = 0; low_run = 0; idle_run = 0;
    wmin = 1000; wmax = 0; gap_min = 1000; setup_seen = -1; hold_seen = -1;
    first = 1; widx = 0;
  endtask

  always @(negedge clk) begin
    bit strb, act;
    cyc++;
    strb = !dev_rd_n || !dev_wr_n;
    act  = (dev_ack == ack_hi_b);
    if (strb) begin
      if (!p_strb) begin
        if (first) begin setup_seen = idle_run; first = 0; end
        else if (idle_run < gap_min) gap_min = idle_run;
        idle_run = 0; low_run = 0;
        if (!dev_rd_n) begin nrd++; dev_din = rpat(nstrb); end
        if (!dev_wr_n) begin nwr++; wlog[nstrb & 255] = dev_dout; end
        nstrb++;
      end
      low_run++;
    end else begin
      if (p_strb) begin
        if (low_run < wmin) wmin = low_run;
        if (low_run > wmax) wmax = low_run;
      end
      if (act) idle_run++;
      else if (p_act) begin hold_seen = idle_run; idle_run = 0; first = 1; end
    end
    p_strb = strb; p_act = act;
    if (out_valid && out_ready) begin olog[nout & 255] = out_data; nout++; end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask
  task automatic set_tim(input int su, input int ho, input int pa, input int rq, input int m,
                         input bit ah, input int ron, input int roff, input int won, input int woff);
    wr_reg(3'd1, {13'd0, ah, 2'(m), 4'(rq), 4'(pa), 4'(ho), 4'(su)});
    wr_reg(3'd2, {16'd0, 4'(woff), 4'(won), 4'(roff), 4'(ron)});
    ack_hi_b = ah;
  endtask
  function automatic logic [31:0] cfgw(input bit en, input bit clr, input bit s, input bit d, input int len);
    return {en, 8'd0, clr, s, d, 20'(len)};
  endfunction
  task automatic wait_done(input int lim);
    logic [31:0] d;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); rd_reg(3'd3, d);
      if (d[0]) break;
    end
  endtask

  task automatic check_data(input int n, input bit d, input bit s, input string req);
    bit ok = 1;
    logic [15:0] a = 0, e = 0;
    for (int i = 0; i < n; i++) begin
      if (d) begin a = wlog[i]; e = sw(wpat(i), s); end
      else   begin a = olog[i]; e = sw(rpat(i), s); end
      if (a !== e && ok) begin ok = 0; chk(0, req, a, e); end
    end
    if (ok) chk(1, req, 0, 0);
  endtask

  logic [31:0] rv;

  initial begin
    void'($urandom(32'd20240611));
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dev_ack == 1'b1 && dev_rd_n && dev_wr_n, "R1 pins idle", {dev_ack, dev_rd_n, dev_wr_n}, 3'b111);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd_reg(3'd0, rv); chk(rv == 32'h000FFFFF, "R1 cfg reset", rv, 32'h000FFFFF);
    rd_reg(3'd3, rv); chk(rv == 32'h0, "R1 status reset", rv, 0);

    wr_reg(3'd4, 32'd1);
    dev_dmarq = 1'b1; in_valid = 1'b1; out_ready = 1'b1;

    // random bursts: R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 8; t++) begin
      int su, ho, pa, m, ron, roff, won, woff, n, on, off;
      bit d, s;
      su = $urandom_range(3); ho = $urandom_range(3); pa = $urandom_range(3);
      m = $urandom_range(3); ron = $urandom_range(3); roff = $urandom_range(3);
      won = $urandom_range(3); woff = $urandom_range(3);
      n = $urandom_range(12, 1); d = 1'($urandom_range(1)); s = 1'($urandom_range(1));
      rbase = 16'($urandom); wbase = 16'($urandom);
      set_tim(su, ho, pa, 0, m, 1'b0, ron, roff, won, woff);
      clear_stats();
      wr_reg(3'd0, cfgw(1, 0, s, d, n - 1));
      wait_done(2000);
      repeat (2) @(negedge clk);
      on  = dcl(d ? won : ron, m);
      off = dcl(d ? woff : roff, m);
      chk(nstrb == n, "R2 word count", nstrb, n);
      chk(d ? (nrd == 0 && dev_drive == 0) : (nwr == 0), "R5 other strobe idle", d ? nrd : nwr, 0);
      chk(d ? (widx == n) : (nout == n), "R5 stream words", d ? widx : nout, n);
      check_data(n, d, s, "R6 data/swap");
      chk(wmin == on && wmax == on, "R7 strobe width", wmax, on);
      if (n > 1) chk(gap_min >= off, "R7 negated width", gap_min, off);
      chk(setup_seen == dcl(su, m), "R8 setup span", setup_seen, dcl(su, m));
      chk(hold_seen == dcl(ho, m), "R8 hold span", hold_seen, dcl(ho, m));
      rd_reg(3'd0, rv);
      chk(rv == cfgw(0, 0, s, d, 20'hFFFFF), "R3 cfg after done", rv, cfgw(0, 0, s, d, 20'hFFFFF));
      chk(irq == 1'b1, "R4 irq on done", irq, 1);
      wr_reg(3'd3, 32'd1);
      rd_reg(3'd3, rv);
      chk(rv[0] == 0 && irq == 0, "R4 done W1C", {rv[0], irq}, 0);
    end

    // R4: interrupt gated off
    wr_reg(3'd4, 32'd0);
    set_tim(0, 0, 0, 0, 1, 1'b0, 0, 0, 0, 0);
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 0, 2));
    wait_done(500);
    rd_reg(3'd3, rv);
    chk(rv[0] == 1 && irq == 0, "R4 irq gated", {rv[0], irq}, 2'b10);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd4, 32'd1);

    // R14: active-high acknowledge
    set_tim(1, 1, 0, 0, 1, 1'b1, 1, 1, 1, 1);
    @(negedge clk);
    chk(dev_ack == 1'b0, "R14 idle level high-pol", dev_ack, 0);
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 0, 3));
    repeat (2) @(negedge clk);
    chk(dev_ack == 1'b1, "R14 active level high-pol", dev_ack, 1);
    wait_done(500);
    chk(nstrb == 4 && setup_seen == 2, "R14 burst with high-pol", nstrb, 4);
    wr_reg(3'd3, 32'd1);

    // R9: request must be held past the raw threshold (mult 4x would differ)
    set_tim(0, 0, 0, 6, 0, 1'b0, 0, 0, 0, 0);
    dev_dmarq = 1'b0;
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    dev_dmarq = 1'b1;
    repeat (3) @(negedge clk);
    dev_dmarq = 1'b0;
    repeat (4) @(negedge clk);
    chk(dev_ack == 1'b1, "R9 short request ignored", dev_ack, 1);
    dev_dmarq = 1'b1;
    repeat (6) @(negedge clk);
    chk(dev_ack == 1'b1, "R9 not yet started", dev_ack, 1);
    @(negedge clk);
    chk(dev_ack == 1'b0, "R9 starts after threshold", dev_ack, 0);
    wait_done(500);
    wr_reg(3'd3, 32'd1);

    // R10: ride through a request drop
    set_tim(0, 0, 0, 0, 1, 1'b0, 0, 0, 0, 0);
    rbase = 16'h5AA5;
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 1, 0, 9));
    while (nstrb < 3) @(negedge clk);
    dev_dmarq = 1'b0;
    repeat (6) @(negedge clk);
    rv = 32'(nstrb);
    repeat (24) @(negedge clk);
    chk(32'(nstrb) == rv && dev_ack == 1'b0, "R10 paused with ack held", nstrb, rv);
    dev_dmarq = 1'b1;
    wait_done(500);
    repeat (2) @(negedge clk);
    chk(nstrb == 10 && nout == 10, "R10 completes in full", nout, 10);
    check_data(10, 0, 1, "R10 data after pause");
    rd_reg(3'd0, rv);
    chk(rv[19:0] == 20'hFFFFF, "R10 length all ones", rv[19:0], 20'hFFFFF);
    wr_reg(3'd3, 32'd1);

    // R11: request drop ends the burst early
    clear_stats();
    wr_reg(3'd0, cfgw(1, 1, 0, 0, 9));
    while (nstrb < 3) @(negedge clk);
    dev_dmarq = 1'b0;
    wait_done(500);
    repeat (2) @(negedge clk);
    rd_reg(3'd0, rv);
    chk(nstrb < 10, "R11 stopped early", nstrb, 10);
    chk(rv[19:0] == 20'(9 - nstrb) && rv[31] == 0, "R11 words left", rv[19:0], 9 - nstrb);
    rd_reg(3'd3, rv);
    chk(rv[0] == 1, "R11 done set", rv[0], 1);
    wr_reg(3'd3, 32'd1);
    dev_dmarq = 1'b1;

    // R12: stop write
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 1, 199));
    while (nstrb < 5) @(negedge clk);
    wr_reg(3'd0, 32'h000FFFFF);
    chk(dev_ack == 1'b1 && dev_wr_n && dev_rd_n, "R12 ack drops at once", dev_ack, 1);
    rv = 32'(nstrb);
    repeat (40) @(negedge clk);
    chk(32'(nstrb) == rv, "R12 no further strobes", nstrb, rv);
    rd_reg(3'd0, rv);
    chk(rv == 32'h000FFFFF, "R12 cfg idle", rv, 32'h000FFFFF);
    rd_reg(3'd3, rv);
    chk(rv[0] == 0, "R12 done not set", rv[0], 0);

    // R13: output stream back-pressure on reads
    set_tim(0, 0, 0, 0, 1, 1'b0, 0, 2, 0, 2);
    rbase = 16'h0FF0;
    out_ready = 1'b0;
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 0, 7));
    repeat (40) @(negedge clk);
    chk(nstrb == 1, "R13 read stalls after one word", nstrb, 1);
    out_ready = 1'b1;
    wait_done(500);
    repeat (2) @(negedge clk);
    chk(nout == 8, "R13 read words after release", nout, 8);
    check_data(8, 0, 0, "R13 read data");
    chk(gap_min >= 3, "R13 negated time kept", gap_min, 3);
    wr_reg(3'd3, 32'd1);

    // R13: input stream empty on writes
    in_valid = 1'b0;
    clear_stats();
    wr_reg(3'd0, cfgw(1, 0, 0, 1, 3));
    repeat (40) @(negedge clk);
    chk(nstrb == 0 && dev_ack == 1'b0, "R13 write waits for data", nstrb, 0);
    in_valid = 1'b1;
    wait_done(500);
    chk(nstrb == 4, "R13 write completes", nstrb, 4);
    check_data(4, 1, 0, "R13 write data");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule